// File: doc/BRIEF.md
# Multi-channel event wait/signal unit

This block lets several DMA channel threads rendezvous through a shared set of numbered events. In any cycle each channel may present one request: either "wait for event N" or "signal event N", with N carried in the channel's own event-number field. For every channel the block drives a stall line. While the line is high the channel thread is halted. A halted channel presents no new requests, and any request it does present is ignored. If a channel raises both request lines, the request is taken as a wait.

A signal that finds waiters releases all of them together and leaves nothing behind. A signal that finds no waiter is remembered as a pending flag. The first later waiter consumes that flag, at the cost of one stall cycle. A per-event mode input decides whether a signal on that event is used for this synchronisation or instead raises a sticky interrupt flag that software clears. Same-cycle races resolve by fixed rules: a signal meets same-cycle waiters as if they were already waiting, and the lowest-numbered channel wins a pending flag.

Top module: `evsync_unit`

## Requirements
- R1: A channel that is not stalled and issues a wait on event N, while N is not pending and no event-mode signal on N arrives in the same cycle, has its stall line high from the next cycle on, until it is released.
- R2: An event-mode signal on N releases every channel waiting on N, and all their stall lines go low in the same following cycle.
- R3: An event-mode signal on N that meets at least one waiter (earlier or same-cycle) leaves N not pending in the following cycle.
- R4: An event-mode signal on N with no waiter sets the pending flag of N, and the flag stays set until some channel waits on N.
- R5: A wait on a pending event gives exactly one cycle of stall, and the pending flag is clear in that stall cycle.
- R6: A pending flag serves one waiter only. A channel that waits on N after the flag was consumed stalls until a new signal on N.
- R7: A wait and an event-mode signal on the same event in the same cycle: the waiter is never stalled and the event is not left pending.
- R8: When several channels wait in the same cycle on a pending event, the lowest-numbered one takes the one-cycle path and the others wait for a new signal.
- R9: Bit N of `ev_mode` selects the mode of event N (1 = event, 0 = interrupt). In interrupt mode a signal on N sets `irq[N]` in the next cycle, releases no waiter and does not set pending.
- R10: `irq[N]` stays set until a cycle with `irq_clr[N]` high. If a new interrupt-mode signal on N arrives in that same cycle, the flag stays set.
- R11: Requests presented by a channel whose stall line is high have no effect.
- R12: A cycle with `rst` high clears all stall lines, pending flags and interrupt flags at the next edge. The event number of channel c occupies `ch_event[4c+3:4c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wait_valid | input | NUM_CH | Per-channel wait request |
| signal_valid | input | NUM_CH | Per-channel signal request |
| ch_event | input | NUM_CH*EV_W | Per-channel event number, channel c in slice c |
| ev_mode | input | NUM_EV | Per-event mode, 1 = event, 0 = interrupt |
| irq_clr | input | NUM_EV | Per-event clear of the interrupt flag |
| stall | output | NUM_CH | Per-channel halt indication |
| ev_pending | output | NUM_EV | Pending flags of the events |
| irq | output | NUM_EV | Sticky interrupt flags |

## Verification
The races that matter are a wait and a signal on the same event in one cycle, and two waits on one pending event in one cycle. Both are driven on purpose in directed steps and then occur often in a long random phase, where the event numbers are drawn from a small set. Every cycle the bench compares stall, pending and interrupt outputs against a behavioural model that walks the channels in ascending order. The interrupt-flag set-versus-clear collision is forced the same way.

// File: rtl/evsync_pkg.sv
package evsync_pkg;
   localparam int unsigned MAX_CH = 32;

   // isolate the least significant set bit
   function automatic logic [MAX_CH-1:0] low_bit(input logic [MAX_CH-1:0] v);
      return v & (~v + {{(MAX_CH-1){1'b0}}, 1'b1});
   endfunction
endpackage

// File: rtl/evsync_req_decode.sv
module evsync_req_decode #(
   parameter int NUM_CH = 8,
   parameter int NUM_EV = 16,
   parameter int EV_W   = 4
) (
   input  logic [NUM_CH-1:0]                  wait_valid,
   input  logic [NUM_CH-1:0]                  signal_valid,
   input  logic [NUM_CH*EV_W-1:0]             ch_event,
   input  logic [NUM_CH-1:0]                  busy,
   output logic [NUM_EV-1:0][NUM_CH-1:0]      wait_by_ev,
   output logic [NUM_EV-1:0]                  sig_hit
);
   logic [NUM_CH-1:0] do_wait, do_sig;

   assign do_wait = wait_valid & ~busy;
   assign do_sig  = signal_valid & ~wait_valid & ~busy;

   for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
      logic [NUM_CH-1:0] sig_row;
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic match;
         assign match            = (ch_event[c*EV_W +: EV_W] == EV_W'(e));
         assign wait_by_ev[e][c] = do_wait[c] & match;
         assign sig_row[c]       = do_sig[c] & match;
      end
      assign sig_hit[e] = |sig_row;
   end
endmodule

// File: rtl/evsync_event_slice.sv
module evsync_event_slice
   import evsync_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] new_wait,
   input  logic [NUM_CH-1:0] waiting_on,
   input  logic              sig_hit,
   input  logic              mode_event,
   input  logic              clr,
   output logic [NUM_CH-1:0] release_o,
   output logic [NUM_CH-1:0] consume_o,
   output logic [NUM_CH-1:0] park_o,
   output logic              pending_o,
   output logic              irq_o
);
   logic pend_q, pend_d, irq_q, irq_d;
   logic ev_sig, irq_sig;
   logic [MAX_CH-1:0] first_w;

   assign ev_sig  = sig_hit & mode_event;
   assign irq_sig = sig_hit & ~mode_event;
   assign first_w = low_bit(MAX_CH'(new_wait));

   always_comb begin
      release_o = '0;
      consume_o = '0;
      park_o    = '0;
      pend_d    = pend_q;
      if (ev_sig) begin
         release_o = waiting_on;
         pend_d    = ~(|waiting_on | |new_wait);
      end else if (pend_q && |new_wait) begin
         consume_o = first_w[NUM_CH-1:0];
         park_o    = new_wait & ~first_w[NUM_CH-1:0];
         pend_d    = 1'b0;
      end else begin
         park_o = new_wait;
      end
      irq_d = irq_sig | (irq_q & ~clr);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         pend_q <= pend_d;
         irq_q  <= irq_d;
      end
   end

   assign pending_o = pend_q;
   assign irq_o     = irq_q;
endmodule

// File: rtl/evsync_unit.sv
module evsync_unit
   import evsync_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int NUM_EV = 16,
   parameter int EV_W   = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [NUM_CH-1:0]      wait_valid,
   input  logic [NUM_CH-1:0]      signal_valid,
   input  logic [NUM_CH*EV_W-1:0] ch_event,
   input  logic [NUM_EV-1:0]      ev_mode,
   input  logic [NUM_EV-1:0]      irq_clr,
   output logic [NUM_CH-1:0]      stall,
   output logic [NUM_EV-1:0]      ev_pending,
   output logic [NUM_EV-1:0]      irq
);
   if (NUM_CH < 1 || NUM_CH > int'(MAX_CH)) begin : g_bad_ch
      $error("evsync_unit: NUM_CH out of range");
   end
   if (NUM_EV < 2) begin : g_bad_ev
      $error("evsync_unit: NUM_EV must be at least 2");
   end
   if ((1 << EV_W) < NUM_EV) begin : g_bad_w
      $error("evsync_unit: EV_W too narrow for NUM_EV");
   end

   logic [NUM_CH-1:0]             waiting_q, hold_q;
   logic [NUM_CH-1:0][EV_W-1:0]   wait_ev_q;
   logic [NUM_EV-1:0][NUM_CH-1:0] wait_by_ev, waiting_on;
   logic [NUM_EV-1:0][NUM_CH-1:0] rel_by_ev, cons_by_ev, park_by_ev;
   logic [NUM_EV-1:0]             sig_hit;
   logic [NUM_CH-1:0]             rel_any, cons_any, park_any;

   assign stall = waiting_q | hold_q;

   evsync_req_decode #(.NUM_CH(NUM_CH), .NUM_EV(NUM_EV), .EV_W(EV_W)) u_dec (
      .wait_valid   (wait_valid),
      .signal_valid (signal_valid),
      .ch_event     (ch_event),
      .busy         (stall),
      .wait_by_ev   (wait_by_ev),
      .sig_hit      (sig_hit)
   );

   for (genvar e = 0; e < NUM_EV; e++) begin : g_slice
      for (genvar c = 0; c < NUM_CH; c++) begin : g_on
         assign waiting_on[e][c] = waiting_q[c] & (wait_ev_q[c] == EV_W'(e));
      end
      evsync_event_slice #(.NUM_CH(NUM_CH)) u_ev (
         .clk        (clk),
         .rst        (rst),
         .new_wait   (wait_by_ev[e]),
         .waiting_on (waiting_on[e]),
         .sig_hit    (sig_hit[e]),
         .mode_event (ev_mode[e]),
         .clr        (irq_clr[e]),
         .release_o  (rel_by_ev[e]),
         .consume_o  (cons_by_ev[e]),
         .park_o     (park_by_ev[e]),
         .pending_o  (ev_pending[e]),
         .irq_o      (irq[e])
      );
   end

   always_comb begin
      rel_any  = '0;
      cons_any = '0;
      park_any = '0;
      for (int e = 0; e < NUM_EV; e++) begin
         rel_any  = rel_any  | rel_by_ev[e];
         cons_any = cons_any | cons_by_ev[e];
         park_any = park_any | park_by_ev[e];
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      always_ff @(posedge clk) begin
         if (rst) begin
            waiting_q[c] <= 1'b0;
            hold_q[c]    <= 1'b0;
            wait_ev_q[c] <= '0;
         end else begin
            waiting_q[c] <= (waiting_q[c] & ~rel_any[c]) | park_any[c];
            hold_q[c]    <= cons_any[c];
            if (park_any[c]) wait_ev_q[c] <= ch_event[c*EV_W +: EV_W];
         end
      end
   end
endmodule

// File: rtl/evsync_chk.sv
module evsync_chk #(
   parameter int NUM_CH = 8,
   parameter int NUM_EV = 16,
   parameter int EV_W   = 4
) (
   input logic                   clk,
   input logic                   rst,
   input logic [NUM_CH-1:0]      wait_valid,
   input logic [NUM_CH-1:0]      signal_valid,
   input logic [NUM_CH*EV_W-1:0] ch_event,
   input logic [NUM_EV-1:0]      ev_mode,
   input logic [NUM_EV-1:0]      irq_clr,
   input logic [NUM_CH-1:0]      stall,
   input logic [NUM_EV-1:0]      ev_pending,
   input logic [NUM_EV-1:0]      irq
);
   logic [NUM_EV-1:0] sig_ev, sig_irq, new_wait_ev;
   logic [NUM_CH-1:0][EV_W-1:0] cap_ev;

   always_comb begin
      sig_ev      = '0;
      sig_irq     = '0;
      new_wait_ev = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (!stall[c] && wait_valid[c])
            new_wait_ev[ch_event[c*EV_W +: EV_W]] = 1'b1;
         else if (!stall[c] && signal_valid[c]) begin
            if (ev_mode[ch_event[c*EV_W +: EV_W]]) sig_ev[ch_event[c*EV_W +: EV_W]] = 1'b1;
            else sig_irq[ch_event[c*EV_W +: EV_W]] = 1'b1;
         end
      end
   end

   // R12: reset clears every output flag
   a_r12_reset_clear: assert property (@(posedge clk)
      rst |=> (stall == '0 && ev_pending == '0 && irq == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      always_ff @(posedge clk) begin
         if (rst) cap_ev[c] <= '0;
         else if (!stall[c] && wait_valid[c]) cap_ev[c] <= ch_event[c*EV_W +: EV_W];
      end

      a_r1_wait_stalls: assert property (@(posedge clk) disable iff (rst)
         (!stall[c] && wait_valid[c] && !ev_pending[ch_event[c*EV_W +: EV_W]]
          && !sig_ev[ch_event[c*EV_W +: EV_W]]) |=> stall[c]);

      a_r2_signal_releases: assert property (@(posedge clk) disable iff (rst)
         (stall[c] && sig_ev[cap_ev[c]]) |=> !stall[c]);

      a_r7_same_cycle_pass: assert property (@(posedge clk) disable iff (rst)
         (!stall[c] && wait_valid[c] && sig_ev[ch_event[c*EV_W +: EV_W]]) |=> !stall[c]);
   end

   for (genvar e = 0; e < NUM_EV; e++) begin : g_e
      a_r4_pending_holds: assert property (@(posedge clk) disable iff (rst)
         (ev_pending[e] && !new_wait_ev[e]) |=> ev_pending[e]);

      a_r5_pending_consumed: assert property (@(posedge clk) disable iff (rst)
         (ev_pending[e] && new_wait_ev[e]) |=> !ev_pending[e]);

      a_r9_irq_sets: assert property (@(posedge clk) disable iff (rst)
         sig_irq[e] |=> irq[e]);

      a_r9_irq_no_pending: assert property (@(posedge clk) disable iff (rst)
         (!ev_pending[e] && sig_irq[e]) |=> !ev_pending[e]);

      a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
         (irq[e] && !irq_clr[e]) |=> irq[e]);
   end
endmodule

bind evsync_unit evsync_chk #(.NUM_CH(NUM_CH), .NUM_EV(NUM_EV), .EV_W(EV_W)) u_chk (
   .clk(clk), .rst(rst), .wait_valid(wait_valid), .signal_valid(signal_valid),
   .ch_event(ch_event), .ev_mode(ev_mode), .irq_clr(irq_clr),
   .stall(stall), .ev_pending(ev_pending), .irq(irq)
);

// File: tb/sim_evsync_unit.sv
module sim_evsync_unit;
   localparam int NC = 8;
   localparam int NE = 16;
   localparam int EW = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NC-1:0] wv = '0, sv = '0;
   logic [NE-1:0] mode = '1, clr = '0;
   logic [NC*EW-1:0] evf;
   int ev_sel [NC];
   logic [NC-1:0] stall;
   logic [NE-1:0] pend, irq;

   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   always_comb
      for (int c = 0; c < NC; c++) evf[c*EW +: EW] = EW'(ev_sel[c]);

   evsync_unit #(.NUM_CH(NC), .NUM_EV(NE), .EV_W(EW)) u0 (
      .clk(clk), .rst(rst), .wait_valid(wv), .signal_valid(sv), .ch_event(evf),
      .ev_mode(mode), .irq_clr(clr), .stall(stall), .ev_pending(pend), .irq(irq)
   );

   // behavioural reference model
   bit m_wait [NC], m_hold [NC], m_pend [NE], m_irq [NE];
   int m_wev [NC];

   always @(posedge clk) begin
      bit w [NC], s [NC];
      bit nw [NC], nh [NC], np [NE], ni [NE];
      int nwev [NC];
      if (rst) begin
         for (int c = 0; c < NC; c++) begin m_wait[c] = 0; m_hold[c] = 0; m_wev[c] = 0; end
         for (int e = 0; e < NE; e++) begin m_pend[e] = 0; m_irq[e] = 0; end
      end else begin
         for (int c = 0; c < NC; c++) begin
            bit busy;
            busy = m_wait[c] | m_hold[c];
            w[c] = !busy && wv[c];
            s[c] = !busy && sv[c] && !wv[c];
            nw[c] = m_wait[c]; nh[c] = 0; nwev[c] = m_wev[c];
         end
         for (int e = 0; e < NE; e++) begin
            bit sig, anyw, taken;
            sig = 0; anyw = 0; taken = 0;
            np[e] = m_pend[e]; ni[e] = m_irq[e];
            for (int c = 0; c < NC; c++) if (s[c] && ev_sel[c] == e) sig = 1;
            if (sig && mode[e]) begin
               for (int c = 0; c < NC; c++) begin
                  if (m_wait[c] && m_wev[c] == e) begin nw[c] = 0; anyw = 1; end
                  if (w[c] && ev_sel[c] == e) anyw = 1;
               end
               np[e] = !anyw;
            end else begin
               for (int c = 0; c < NC; c++)
                  if (w[c] && ev_sel[c] == e) begin
                     if (m_pend[e] && !taken) begin nh[c] = 1; taken = 1; end
                     else begin nw[c] = 1; nwev[c] = e; end
                  end
               if (taken) np[e] = 0;
            end
            if (clr[e]) ni[e] = 0;
            if (sig && !mode[e]) ni[e] = 1;
         end
         for (int c = 0; c < NC; c++) begin m_wait[c] = nw[c]; m_hold[c] = nh[c]; m_wev[c] = nwev[c]; end
         for (int e = 0; e < NE; e++) begin m_pend[e] = np[e]; m_irq[e] = ni[e]; end
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (all requirements)
   always @(negedge clk) begin
      if (!rst) begin
         for (int c = 0; c < NC; c++) chk($sformatf("model stall ch%0d", c), stall[c], m_wait[c] | m_hold[c]);
         for (int e = 0; e < NE; e++) begin
            chk($sformatf("model pending ev%0d", e), pend[e], m_pend[e]);
            chk($sformatf("model irq ev%0d", e), irq[e], m_irq[e]);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      wv = '0; sv = '0; clr = '0;
   endtask

   task automatic req_wait(input int c, input int e);
      wv[c] = 1'b1; ev_sel[c] = e;
   endtask

   task automatic req_sig(input int c, input int e);
      sv[c] = 1'b1; ev_sel[c] = e;
   endtask

   initial begin
      #1600000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < NC; c++) ev_sel[c] = 0;
      mode = '1; mode[15] = 1'b0;
      @(negedge clk); @(negedge clk);
      step();
      rst = 1'b0;
      chk("R12 reset stall", |stall, 1'b0);
      chk("R12 reset pending", |pend, 1'b0);
      chk("R12 reset irq", |irq, 1'b0);

      // R1: lone waiter stalls and stays stalled
      req_wait(0, 3); step();
      chk("R1 stall after wait", stall[0], 1'b1);
      step(); step();
      chk("R1 still stalled", stall[0], 1'b1);

      // R2/R3: one signal releases two waiters, no pending left
      req_wait(1, 3); step();
      chk("R1 second waiter", stall[1], 1'b1);
      req_sig(2, 3); step();
      chk("R2 release ch0", stall[0], 1'b0);
      chk("R2 release ch1", stall[1], 1'b0);
      chk("R3 no pending", pend[3], 1'b0);

      // R4: unanswered signal stays pending
      req_sig(2, 5); step();
      chk("R4 pending set", pend[5], 1'b1);
      step();
      chk("R4 pending held", pend[5], 1'b1);

      // R5/R8: two same-cycle waiters on a pending event
      req_wait(4, 5); req_wait(3, 5); step();
      chk("R5 one-cycle stall", stall[3], 1'b1);
      chk("R5 pending cleared", pend[5], 1'b0);
      chk("R8 loser stalled", stall[4], 1'b1);
      step();
      chk("R5 winner resumes", stall[3], 1'b0);
      chk("R8 loser still waits", stall[4], 1'b1);
      req_sig(5, 5); step();
      chk("R8 loser released", stall[4], 1'b0);

      // R6: consumed flag serves nobody else
      req_sig(2, 6); step();
      req_wait(0, 6); step(); step();
      chk("R6 first consumer done", stall[0], 1'b0);
      req_wait(1, 6); step(); step();
      chk("R6 later waiter stalls", stall[1], 1'b1);
      req_sig(2, 6); step();
      chk("R6 released by new signal", stall[1], 1'b0);

      // R7: same-cycle wait and signal
      req_wait(0, 7); req_sig(1, 7); step();
      chk("R7 waiter not stalled", stall[0], 1'b0);
      chk("R7 not pending", pend[7], 1'b0);

      // R11: stalled channel requests ignored
      req_wait(0, 8); step();
      req_sig(0, 9); step();
      chk("R11 ignored signal", pend[9], 1'b0);
      chk("R11 still stalled", stall[0], 1'b1);
      req_sig(1, 8); step();
      chk("R11 released later", stall[0], 1'b0);

      // R9/R10: interrupt-mode event
      req_wait(2, 15); step();
      req_sig(3, 15); step();
      chk("R9 irq set", irq[15], 1'b1);
      chk("R9 waiter kept", stall[2], 1'b1);
      chk("R9 no pending", pend[15], 1'b0);
      step();
      chk("R10 irq sticky", irq[15], 1'b1);
      clr[15] = 1'b1; req_sig(3, 15); step();
      chk("R10 set beats clear", irq[15], 1'b1);
      clr[15] = 1'b1; step();
      chk("R10 cleared", irq[15], 1'b0);
      mode[15] = 1'b1; req_sig(3, 15); step();
      chk("R2 release after mode change", stall[2], 1'b0);

      // random phase with dense event collisions
      for (int n = 0; n < 3000; n++) begin
         for (int c = 0; c < NC; c++) begin
            int r;
            r = int'($urandom % 8);
            ev_sel[c] = ($urandom % 5 == 0) ? 15 : int'($urandom % 4);
            if (r == 0) wv[c] = 1'b1;
            else if (r == 1) sv[c] = 1'b1;
         end
         clr = NE'($urandom) & NE'($urandom) & NE'($urandom);
         if (n % 97 == 0) mode[15] = ~mode[15];
         if (n == 1500) rst = 1'b1;
         step();
         if (n == 1500) begin
            rst = 1'b0;
            chk("R12 mid-run reset stall", |stall, 1'b0);
            chk("R12 mid-run reset pending", |pend, 1'b0);
            chk("R12 mid-run reset irq", |irq, 1'b0);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule